// File: doc/BRIEF.md
# Framed 130-Bit Block Scrambler

This block conditions a serial bit stream for a link that carries 130-bit blocks. Each block starts with two sync-header bits and continues with 128 payload bits. Payload bits are combined by exclusive-or with a pseudo-random sequence from a 23-bit Fibonacci LFSR built on the polynomial x^23 + x^21 + 1. The sync header is forwarded untouched and does not advance the sequence. The block accepts one bit per clock under a valid strobe. Idle cycles are allowed anywhere, and the LFSR state does not change on them.

A start-of-block marker realigns the internal bit-position tracking. Without the marker, the position wraps to a new block on its own after 130 valid bits. A reseed request loads the all-ones seed into the LFSR, so both ends of the link restart the sequence at boundaries they agree on. Because the operation is its own inverse, the same module serves as the descrambler. A second instance fed with the scrambled stream, and given the same marker and reseed timing, returns the original bits. A sync header of 00 or 11 raises a one-cycle error flag and is still forwarded.

Top module: `blk130_scrambler`

## Requirements
- R1: While reset is low, `dout_vld`, `dout` and `hdr_err` are 0. Reset leaves the LFSR at the all-ones seed and the bit position at 0.
- R2: `dout_vld` equals `din_vld` delayed by exactly one clock. `dout` is updated only for valid inputs and holds its value otherwise.
- R3: A valid bit at block position 0 or 1 (the sync header) appears on `dout` one cycle later, unchanged.
- R4: A valid bit at positions 2 to 129 leaves as `din` XOR f, where f = s[22] XOR s[20] of the current LFSR state s. The state then becomes {s[21:0], f}. The state is never all zero.
- R5: The LFSR advances only on valid payload bits. Idle cycles and header bits leave it unchanged, so idle gaps do not alter the output sequence.
- R6: `din_sob` together with `din_vld` places that bit at position 0. Each valid bit advances the position, and the position wraps from 129 to 0 without a marker.
- R7: `reseed` loads 0x7FFFFF after the current bit is processed and takes priority over stepping. A reseed with a block's first header bit makes the first payload bit of that block use the seed.
- R8: If the two header bits of a block are equal (00 or 11), `hdr_err` is 1 for exactly the one cycle in which the second header bit appears on `dout`. Headers 01 and 10 never raise it.
- R9: A second instance fed with `dout`/`dout_vld`, with marker and reseed delayed by one cycle, reproduces the original valid bits exactly.
- R10: After a reseed, an all-zero 128-bit payload leaves the scrambler with at least 8 bit transitions across its 128 output bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial input bit |
| din_vld | input | 1 | `din` carries a bit this cycle |
| din_sob | input | 1 | With `din_vld`, marks the first header bit of a block |
| reseed | input | 1 | Return the LFSR to the seed after this cycle |
| dout | output | 1 | Processed bit, one cycle after its input |
| dout_vld | output | 1 | `dout` carries a bit this cycle |
| hdr_err | output | 1 | One-cycle pulse for an illegal sync header |

## Verification
The bound checker watches, on every cycle, the one-cycle valid pipeline and the unchanged forwarding of header bits. It also checks that the LFSR holds still on idle and header cycles, moves on payload cycles, returns to the seed after a reseed and never reaches zero. Position forcing, position wrap and the single-cycle, header-only nature of the error pulse are checked there as well. The exact pseudo-random values, the immunity of the output sequence to idle gaps, the reseed timing at a block's first bit and bit-exact recovery through a chained descrambler can only be shown by the bench's scenarios. The same holds for the transition count of a scrambled all-zero payload. Those scenarios compare against an independent cycle model.

// File: rtl/blkscr_pkg.sv
package blkscr_pkg;

  // Framing: a sync header of fixed length followed by the payload.
  localparam int SYNC_BITS    = 2;
  localparam int PAYLOAD_BITS = 128;

  // Default sequence generator: x^23 + x^21 + 1, Fibonacci form.
  localparam int LFSR_BITS  = 23;
  localparam int TAP_HI_DEF = 22;
  localparam int TAP_LO_DEF = 20;

  // Role of the bit presented on the input this cycle.
  typedef enum logic [1:0] {
    ROLE_IDLE = 2'd0,
    ROLE_SYNC = 2'd1,
    ROLE_DATA = 2'd2
  } bit_role_e;

  // A sync header is legal only when its two bits differ.
  function automatic logic sync_is_legal(input logic first_bit, input logic second_bit);
    return first_bit ^ second_bit;
  endfunction

endpackage

// File: rtl/blkscr_pos_track.sv
module blkscr_pos_track
  import blkscr_pkg::*;
#(
  parameter int BLK = SYNC_BITS + PAYLOAD_BITS,
  parameter int HDR = SYNC_BITS,
  parameter int PW  = $clog2(BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          sob,
  output logic [PW-1:0] cur_pos,
  output bit_role_e     role
);

  localparam logic [PW-1:0] LAST_POS = PW'(BLK - 1);
  localparam logic [PW-1:0] HDR_END  = PW'(HDR);

  logic [PW-1:0] pos_q;

  // Position of the bit on the input now; the marker overrides the count.
  always_comb begin
    cur_pos = (vld && sob) ? '0 : pos_q;
    if (!vld)                 role = ROLE_IDLE;
    else if (cur_pos < HDR_END) role = ROLE_SYNC;
    else                      role = ROLE_DATA;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (vld) begin
      pos_q <= (cur_pos == LAST_POS) ? '0 : cur_pos + PW'(1);
    end
  end

endmodule

// File: rtl/blkscr_lfsr.sv
module blkscr_lfsr #(
  parameter int             W      = 23,
  parameter int             TAP_HI = 22,
  parameter int             TAP_LO = 20,
  parameter logic [W-1:0]   SEED   = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         reseed,
  output logic [W-1:0] state,
  output logic         fb
);

  function automatic logic fb_of(input logic [W-1:0] s);
    return s[TAP_HI] ^ s[TAP_LO];
  endfunction

  function automatic logic [W-1:0] next_of(input logic [W-1:0] s);
    return {s[W-2:0], fb_of(s)};
  endfunction

  logic [W-1:0] st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SEED;
    end else if (reseed) begin
      st_q <= SEED;
    end else if (step) begin
      st_q <= next_of(st_q);
    end
  end

  assign state = st_q;
  assign fb    = fb_of(st_q);

endmodule

// File: rtl/blkscr_sync_check.sv
module blkscr_sync_check
  import blkscr_pkg::*;
#(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vld,
  input  logic          bit_in,
  input  logic [PW-1:0] pos,
  output logic          err
);

  logic first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (vld && pos == '0) first_q <= bit_in;
      err <= vld && (pos == PW'(1)) && !sync_is_legal(first_q, bit_in);
    end
  end

endmodule

// File: rtl/blk130_scrambler.sv
module blk130_scrambler
  import blkscr_pkg::*;
#(
  parameter int                  PAY_BITS = PAYLOAD_BITS,
  parameter int                  LFSR_W   = LFSR_BITS,
  parameter int                  TAP_HI   = TAP_HI_DEF,
  parameter int                  TAP_LO   = TAP_LO_DEF,
  parameter logic [LFSR_W-1:0]   SEED     = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic din_vld,
  input  logic din_sob,
  input  logic reseed,
  output logic dout,
  output logic dout_vld,
  output logic hdr_err
);

  localparam int BLK_BITS = SYNC_BITS + PAY_BITS;
  localparam int POS_W    = $clog2(BLK_BITS);

  // Named internal events, also observed by the bound checker.
  logic [POS_W-1:0]  cur_pos;
  bit_role_e         role;
  logic              is_hdr;
  logic              pay_step;
  logic [LFSR_W-1:0] lfsr_state;
  logic              lfsr_fb;
  logic              bit_next;

  blkscr_pos_track #(
    .BLK (BLK_BITS),
    .HDR (SYNC_BITS),
    .PW  (POS_W)
  ) i_pos (
    .clk     (clk),
    .rst_n   (rst_n),
    .vld     (din_vld),
    .sob     (din_sob),
    .cur_pos (cur_pos),
    .role    (role)
  );

  assign is_hdr   = (role == ROLE_SYNC);
  assign pay_step = (role == ROLE_DATA);

  blkscr_lfsr #(
    .W      (LFSR_W),
    .TAP_HI (TAP_HI),
    .TAP_LO (TAP_LO),
    .SEED   (SEED)
  ) i_lfsr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (pay_step),
    .reseed (reseed),
    .state  (lfsr_state),
    .fb     (lfsr_fb)
  );

  blkscr_sync_check #(
    .PW (POS_W)
  ) i_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .vld    (din_vld),
    .bit_in (din),
    .pos    (cur_pos),
    .err    (hdr_err)
  );

  // Header bits bypass; payload bits take the feedback bit of this step.
  assign bit_next = pay_step ? (din ^ lfsr_fb) : din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout     <= 1'b0;
      dout_vld <= 1'b0;
    end else begin
      dout_vld <= din_vld;
      if (din_vld) dout <= bit_next;
    end
  end

endmodule

// File: rtl/blk130_scr_checker.sv
module blk130_scr_checker #(
  parameter int                LFSR_W   = 23,
  parameter int                BLK_BITS = 130,
  parameter logic [LFSR_W-1:0] SEED     = '1,
  parameter int                POS_W    = $clog2(BLK_BITS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              din,
  input logic              din_vld,
  input logic              din_sob,
  input logic              reseed,
  input logic              dout,
  input logic              dout_vld,
  input logic              hdr_err,
  input logic [POS_W-1:0]  cur_pos,
  input logic              is_hdr,
  input logic              pay_step,
  input logic [LFSR_W-1:0] lfsr_state
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(BLK_BITS - 1);

  p_vld_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    din_vld |=> dout_vld);

  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> !dout_vld);

  p_hdr_bypass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && is_hdr) |=> (dout == $past(din)));

  p_state_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!reseed && !pay_step) |=> $stable(lfsr_state));

  p_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_step && !reseed) |=> (lfsr_state != $past(lfsr_state)));

  p_sob_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && din_sob) |-> (cur_pos == '0));

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (din_vld && cur_pos == LAST_POS) |=> (cur_pos == '0));

  p_pos_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_pos <= LAST_POS);

  p_reseed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reseed |=> (lfsr_state == SEED));

  p_err_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |-> $past(din_vld && cur_pos == POS_W'(1)));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_err |=> !hdr_err);

endmodule

bind blk130_scrambler blk130_scr_checker #(
  .LFSR_W   (LFSR_W),
  .BLK_BITS (BLK_BITS),
  .SEED     (SEED)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .din        (din),
  .din_vld    (din_vld),
  .din_sob    (din_sob),
  .reseed     (reseed),
  .dout       (dout),
  .dout_vld   (dout_vld),
  .hdr_err    (hdr_err),
  .cur_pos    (cur_pos),
  .is_hdr     (is_hdr),
  .pay_step   (pay_step),
  .lfsr_state (lfsr_state)
);

// File: tb/test_blk130_scrambler.sv
module test_blk130_scrambler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int SEED_VAL   = 'h7FFFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic din = 1'b0, din_vld = 1'b0, din_sob = 1'b0, reseed = 1'b0;
  logic sc_dout, sc_vld, sc_err;
  logic ds_sob = 1'b0, ds_reseed = 1'b0;
  logic ds_dout, ds_vld, ds_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk130_scrambler i_blk130_scrambler (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld), .din_sob(din_sob),
    .reseed(reseed), .dout(sc_dout), .dout_vld(sc_vld), .hdr_err(sc_err)
  );

  // Descrambler: same module, fed from the scrambler output.
  blk130_scrambler i_descrambler (
    .clk(clk), .rst_n(rst_n), .din(sc_dout), .din_vld(sc_vld), .din_sob(ds_sob),
    .reseed(ds_reseed), .dout(ds_dout), .dout_vld(ds_vld), .hdr_err(ds_err)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string scen = "init";

  // Reference model state
  int m_pos  = 0;
  int m_lfsr = SEED_VAL;
  bit m_h0   = 0;
  bit e_dout = 0, e_vld = 0, e_err = 0, e_hdr = 0;
  // previous-step context
  bit p_sob = 0, p_reseed = 0, p_col = 0;
  // two-step pipeline of original bits for the descrambler
  bit q1_d = 0, q1_v = 0, q2_d = 0, q2_v = 0;
  bit zero_run[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", req, scen, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic model(input bit d, input bit v, input bit s, input bit r);
    int p;
    bit f;
    p = (v && s) ? 0 : m_pos;
    f = bit'(((m_lfsr >> 22) ^ (m_lfsr >> 20)) & 1);
    e_vld = v;
    e_err = 0;
    if (v) begin
      e_hdr  = (p < 2);
      e_dout = e_hdr ? d : (d ^ f);
      if (p == 1) e_err = (m_h0 == d);
      if (p == 0) m_h0 = d;
      m_pos = (p == 129) ? 0 : p + 1;
      if (!e_hdr) m_lfsr = ((m_lfsr << 1) | int'(f)) & SEED_VAL;
    end
    if (r) m_lfsr = SEED_VAL;
  endtask

  // One clock: compare outputs of the previous step, then drive the next input.
  task automatic step(input bit d, input bit v, input bit s, input bit r, input bit col);
    @(negedge clk);
    chk(sc_vld == e_vld, "R2 valid delay", int'(sc_vld), int'(e_vld));
    if (e_hdr) chk(sc_dout == e_dout, "R3 header bypass", int'(sc_dout), int'(e_dout));
    else       chk(sc_dout == e_dout, "R4 payload scramble", int'(sc_dout), int'(e_dout));
    chk(sc_err == e_err, "R8 header error", int'(sc_err), int'(e_err));
    chk(ds_vld == q2_v, "R9 descrambler valid", int'(ds_vld), int'(q2_v));
    if (q2_v) chk(ds_dout == q2_d, "R9 recovery", int'(ds_dout), int'(q2_d));
    if (p_col && sc_vld) zero_run.push_back(sc_dout);
    q2_d = q1_d; q2_v = q1_v;
    q1_d = d;    q1_v = v;
    ds_sob    = p_sob;
    ds_reseed = p_reseed;
    p_sob = s; p_reseed = r; p_col = col && v;
    din = d; din_vld = v; din_sob = s; reseed = r;
    model(d, v, s, r);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(bit'($urandom % 2), 0, 0, 0, 0);
  endtask

  // hdr[1] is sent first. rs_at: -1 none, 0 with first header bit, k>=2 with position k.
  task automatic send_block(input bit [1:0] hdr, input bit use_sob, input int rs_at,
                            input int gap_pct, input bit zero_pay, input bit col);
    for (int i = 0; i < 130; i++) begin
      bit b;
      if (gap_pct > 0 && int'($urandom % 100) < gap_pct) idle(1 + int'($urandom % 3));
      if (i < 2) b = hdr[1 - i];
      else       b = zero_pay ? 1'b0 : bit'($urandom % 2);
      step(b, 1, (i == 0) && use_sob, (i == rs_at), col && (i >= 2));
    end
  endtask

  initial begin
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    chk(sc_vld == 1'b0, "R1 reset valid", int'(sc_vld), 0);
    chk(sc_dout == 1'b0, "R1 reset data", int'(sc_dout), 0);
    chk(sc_err == 1'b0, "R1 reset error", int'(sc_err), 0);
    rst_n = 1'b1;
    idle(2);

    // R1 R3 R4: first block straight from reset, no marker, seed from reset
    scen = "R1 first block";
    send_block(2'b01, 0, -1, 0, 0, 0);
    // R6: wrap into next block without a marker
    scen = "R6 wrap";
    send_block(2'b10, 0, -1, 0, 0, 0);
    // R5: idle gaps inside header and payload
    scen = "R5 gaps";
    send_block(2'b01, 1, -1, 30, 0, 0);
    // R7 R10: reseed with first header bit, all-zero payload
    scen = "R7 R10 zero payload";
    zero_run.delete();
    send_block(2'b10, 1, 0, 0, 1, 1);
    idle(1);
    begin
      int tr = 0;
      for (int i = 1; i < zero_run.size(); i++) if (zero_run[i] != zero_run[i-1]) tr++;
      chk(zero_run.size() == 128, "R10 payload count", zero_run.size(), 128);
      chk(tr >= 8, "R10 transitions", tr, 8);
    end
    // R8: illegal headers 00 and 11, then legal 10
    scen = "R8 bad header 00";
    send_block(2'b00, 1, -1, 0, 0, 0);
    scen = "R8 bad header 11";
    send_block(2'b11, 1, -1, 10, 0, 0);
    scen = "R8 good header";
    send_block(2'b10, 1, -1, 0, 0, 0);
    // R6: marker in the middle of a block restarts it
    scen = "R6 mid-block marker";
    for (int i = 0; i < 50; i++) step(bit'($urandom % 2), 1, i == 0, 0, 0);
    send_block(2'b01, 1, -1, 0, 0, 0);
    // R7: reseed in the middle of a payload, and during idle
    scen = "R7 mid reseed";
    send_block(2'b10, 1, 60, 0, 0, 0);
    step(0, 0, 0, 1, 0);
    send_block(2'b01, 1, -1, 0, 0, 0);
    // R9: random blocks, gaps and reseeds through both instances
    scen = "R9 random";
    for (int k = 0; k < 16; k++) begin
      bit [1:0] h;
      h = ($urandom % 2) ? 2'b01 : 2'b10;
      if ($urandom % 4 == 0) step(0, 0, 0, 1, 0);
      send_block(h, bit'($urandom % 2), ($urandom % 3 == 0) ? 0 : -1,
                 int'($urandom % 25), 0, 0);
    end
    idle(4);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog (all requirements) actual=%0d expected=%0d", WATCHDOG, 0);
      summary();
      $finish;
    end
  end

endmodule